// File: doc/BRIEF.md
# Panel Configuration Serial Sequencer

This block loads configuration registers inside a display panel over a three-wire serial link made of an active-low enable, a clock that idles high, and a data line. Each write is one 16-bit frame carrying an 8-bit register address and an 8-bit value. The panel captures one bit on every rising clock edge.

Two fixed command lists are built in: a five-write power-up list and a one-write power-down list. A single pulse on the matching request input plays a list back one write at a time. While the list runs the block holds `busy`, and it raises `done` for one cycle when the last write ends. When idle, the block also takes one write whose address and value come from the host. The half-period of the serial clock is set by the `div_half` input, counted in system clock cycles.

Top module: `panel_cfg_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ser_en`=1, `ser_clk`=1, `ser_dat`=0, `busy`=0 and `done`=0.
- R2: Every frame is 16 bits equal to {address[7:0], value[7:0]}, sent most significant bit first. The receiver samples `ser_dat` on each rising edge of `ser_clk`. `ser_dat` does not change while `ser_clk` is high inside a frame.
- R3: A frame opens with `ser_en` falling while `ser_clk` is high and `ser_dat` is low. It closes with `ser_en` rising after exactly 16 rising clock edges, and `ser_clk` is high when it does. `ser_clk` stays high whenever `ser_en` is high.
- R4: Every low phase and every high phase of `ser_clk` inside a frame lasts H system cycles. H is `div_half`, except that a value of 0 counts as 1.
- R5: A `req_on` pulse sends five writes in this order: 0x05=0x1E, 0x05=0x5E, 0x07=0x8D, 0x13=0x01, 0x05=0x5F.
- R6: A `req_off` pulse sends one write: 0x05=0x5E.
- R7: A `wr_req` pulse sends one write of {`wr_addr`, `wr_data`}, using the values held on those inputs in the cycle of the pulse.
- R8: If requests arrive in the same idle cycle, `req_on` is served first, then `req_off`, then `wr_req`. Only one request is accepted.
- R9: Any request that arrives while `busy` is high is ignored and produces no frame.
- R10: `busy` rises in the cycle after a request is accepted. `done` is high for exactly one cycle, while `busy` is still high, as the final write of the list ends. `busy` is low in the next cycle.
- R11: Between two consecutive writes of one list, `ser_en` stays high for at least 2*H cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_half | input | DIV_W | Serial clock half-period in system cycles (0 treated as 1) |
| req_on | input | 1 | Start the power-up command list |
| req_off | input | 1 | Start the power-down command list |
| wr_req | input | 1 | Start one host-supplied write |
| wr_addr | input | ADDR_W | Register address for the host write |
| wr_data | input | DATA_W | Register value for the host write |
| ser_en | output | 1 | Serial enable, active low |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | A list or a single write is in progress |
| done | output | 1 | One-cycle pulse when the final write completes |

## Verification
A wrong list index or list selection shows up as a wrong 16-bit word, or a wrong number of frames, at the next `ser_en` rising edge. That is at most about 34*H cycles after the fault. A bad phase counter changes the measured low or high width of the very next clock phase. A bit counter that is off by one changes the count of rising edges in the frame, which is visible when the frame closes. A sequencer that gets stuck is exposed when `done` never arrives, and a double completion is exposed by a repeated `done` pulse. The bench rebuilds each frame only from the three pins and compares it with the word required for that position.

// File: rtl/panel_cfg_pkg.sv
package panel_cfg_pkg;

  typedef enum logic [1:0] {
    LST_ON  = 2'd0,
    LST_OFF = 2'd1,
    LST_ONE = 2'd2
  } list_e;

  localparam int unsigned ON_LEN  = 5;
  localparam int unsigned IDX_W   = 3;

  // effective half period: zero behaves as one
  function automatic logic [15:0] eff_half(input logic [15:0] d);
    return (d == '0) ? 16'd1 : d;
  endfunction

  // index of the final write in a list
  function automatic logic [IDX_W-1:0] last_idx(input list_e l);
    return (l == LST_ON) ? IDX_W'(ON_LEN - 1) : '0;
  endfunction

  // fixed command words, {address, value}
  function automatic logic [15:0] list_word(input list_e l,
                                            input logic [IDX_W-1:0] i,
                                            input logic [15:0] host);
    logic [15:0] w;
    w = host;
    if (l == LST_OFF) begin
      w = 16'h055E;
    end else if (l == LST_ON) begin
      case (i)
        3'd0:    w = 16'h051E;
        3'd1:    w = 16'h055E;
        3'd2:    w = 16'h078D;
        3'd3:    w = 16'h1301;
        default: w = 16'h055F;
      endcase
    end
    return w;
  endfunction

endpackage

// File: rtl/panel_cfg_shifter.sv
module panel_cfg_shifter #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              ready,
  output logic              word_done,
  output logic              ser_en,
  output logic              ser_clk,
  output logic              ser_dat
);
  import panel_cfg_pkg::*;

  localparam int unsigned BIT_W = $clog2(WORD_W);

  typedef enum logic [2:0] {
    SH_IDLE, SH_LEAD, SH_LO, SH_HI, SH_GAP
  } sh_state_e;

  sh_state_e         st;
  logic [DIV_W-1:0]  cnt;
  logic [DIV_W-1:0]  reload;
  logic [WORD_W-1:0] sh;
  logic [BIT_W-1:0]  nbit;
  logic              gap2;
  logic              phase_tick;

  assign reload     = DIV_W'(eff_half(16'(div_half)) - 16'd1);
  assign phase_tick = (cnt == '0);
  assign ready      = (st == SH_IDLE);
  assign word_done  = (st == SH_GAP) && phase_tick && gap2;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SH_IDLE;
      cnt  <= '0;
      sh   <= '0;
      nbit <= '0;
      gap2 <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: if (start) begin
          sh  <= word;
          cnt <= reload;
          st  <= SH_LEAD;
        end
        SH_LEAD: if (phase_tick) begin
          cnt  <= reload;
          nbit <= '0;
          st   <= SH_LO;
        end else cnt <= cnt - 1'b1;
        SH_LO: if (phase_tick) begin
          cnt <= reload;
          st  <= SH_HI;
        end else cnt <= cnt - 1'b1;
        SH_HI: if (phase_tick) begin
          cnt <= reload;
          if (nbit == BIT_W'(WORD_W - 1)) begin
            gap2 <= 1'b0;
            st   <= SH_GAP;
          end else begin
            nbit <= nbit + 1'b1;
            sh   <= sh << 1;
            st   <= SH_LO;
          end
        end else cnt <= cnt - 1'b1;
        SH_GAP: if (phase_tick) begin
          cnt <= reload;
          if (gap2) st <= SH_IDLE;
          else      gap2 <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign ser_en  = (st == SH_IDLE) || (st == SH_GAP);
  assign ser_clk = (st != SH_LO);
  assign ser_dat = ((st == SH_LO) || (st == SH_HI)) ? sh[WORD_W-1] : 1'b0;

endmodule

// File: rtl/panel_cfg_sequencer.sv
module panel_cfg_sequencer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_on,
  input  logic                     req_off,
  input  logic                     wr_req,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     sh_ready,
  input  logic                     word_done,
  output logic                     start,
  output logic [ADDR_W+DATA_W-1:0] word,
  output logic                     busy,
  output logic                     done
);
  import panel_cfg_pkg::*;

  logic                     run;
  logic                     issue;
  list_e                    lsel;
  logic [IDX_W-1:0]         idx;
  logic [ADDR_W+DATA_W-1:0] host_w;
  logic                     accept;
  logic                     at_last;

  assign accept  = !run && (req_on || req_off || wr_req);
  assign at_last = (idx == last_idx(lsel));

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      issue  <= 1'b0;
      lsel   <= LST_ON;
      idx    <= '0;
      host_w <= '0;
    end else if (accept) begin
      run   <= 1'b1;
      issue <= 1'b1;
      idx   <= '0;
      if (req_on)       lsel <= LST_ON;
      else if (req_off) lsel <= LST_OFF;
      else begin
        lsel   <= LST_ONE;
        host_w <= {wr_addr, wr_data};
      end
    end else if (run) begin
      if (issue && sh_ready) issue <= 1'b0;
      if (word_done) begin
        if (at_last) run <= 1'b0;
        else begin
          idx   <= idx + 1'b1;
          issue <= 1'b1;
        end
      end
    end
  end

  assign start = run && issue && sh_ready;
  assign word  = (ADDR_W+DATA_W)'(list_word(lsel, idx, 16'(host_w)));
  assign busy  = run;
  assign done  = run && word_done && at_last;

endmodule

// File: rtl/panel_cfg_seq.sv
module panel_cfg_seq #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              req_on,
  input  logic              req_off,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ser_en,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              busy,
  output logic              done
);
  localparam int unsigned WORD_W = ADDR_W + DATA_W;

  logic              start;
  logic              sh_ready;
  logic              word_done;
  logic [WORD_W-1:0] word;

  panel_cfg_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst(rst),
    .req_on(req_on), .req_off(req_off), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sh_ready(sh_ready), .word_done(word_done),
    .start(start), .word(word), .busy(busy), .done(done)
  );

  panel_cfg_shifter #(.DIV_W(DIV_W), .WORD_W(WORD_W)) shf_i (
    .clk(clk), .rst(rst), .div_half(div_half),
    .start(start), .word(word),
    .ready(sh_ready), .word_done(word_done),
    .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat)
  );

endmodule

// File: rtl/panel_cfg_chk.sv
module panel_cfg_chk (
  input logic clk,
  input logic rst,
  input logic ser_en,
  input logic ser_clk,
  input logic ser_dat,
  input logic busy,
  input logic done,
  input logic start,
  input logic word_done
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (ser_en && ser_clk && !ser_dat && !busy && !done));

  // R2
  dat_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!ser_en && ser_clk && $past(ser_clk) && !$past(ser_en) && !$past(rst))
      |-> $stable(ser_dat));

  // R3
  frame_open_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_en) |-> (ser_clk && !ser_dat));

  // R3
  clk_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    ser_en |-> ser_clk);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  done_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy && word_done));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R9
  start_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (busy && ser_en));
endmodule

bind panel_cfg_seq panel_cfg_chk chk_i (
  .clk(clk), .rst(rst), .ser_en(ser_en), .ser_clk(ser_clk),
  .ser_dat(ser_dat), .busy(busy), .done(done),
  .start(start), .word_done(word_done)
);

// File: tb/panel_cfg_seq_tb.sv
`timescale 1ns/1ps
module panel_cfg_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_half = 8'd2;
  logic       req_on = 1'b0, req_off = 1'b0, wr_req = 1'b0;
  logic [7:0] wr_addr = 8'h00, wr_data = 8'h00;
  logic       ser_en, ser_clk, ser_dat, busy, done;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  panel_cfg_seq dut_i (
    .clk(clk), .rst(rst), .div_half(div_half),
    .req_on(req_on), .req_off(req_off), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .busy(busy), .done(done)
  );

  // pin monitor, sampled away from the active edge
  logic [15:0] frames [64];
  int          nframes = 0;
  logic [15:0] sh_m = '0;
  int          bits = 0;
  logic        p_en = 1'b1, p_clk = 1'b1, p_done = 1'b0;
  int          lowlen = 0, highlen = 0, ehlen = 0;
  int          phase_bad = 0, bits_bad = 0, open_bad = 0, gap_bad = 0;
  int          done_cnt = 0, done_wide = 0;
  logic        have_prev = 1'b0;

  function automatic int hval(input logic [7:0] d);
    return (d == 0) ? 1 : int'(d);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (done && p_done) done_wide++;
      if (!busy) have_prev = 1'b0;
      if (p_en && !ser_en) begin
        if (!ser_clk || ser_dat) open_bad++;
        if (have_prev && ehlen < 2*hval(div_half)) gap_bad++;
        bits = 0;
        sh_m = '0;
        highlen = 0;
      end
      if (!ser_en && !p_en) begin
        if (ser_clk && !p_clk) begin
          sh_m = {sh_m[14:0], ser_dat};
          bits++;
          if (lowlen != hval(div_half)) phase_bad++;
          highlen = 0;
        end
        if (!ser_clk && p_clk && bits > 0 && highlen != hval(div_half))
          phase_bad++;
      end
      if (!p_en && ser_en) begin
        if (bits != 16 || !ser_clk) bits_bad++;
        if (bits > 0 && highlen != hval(div_half)) phase_bad++;
        frames[nframes % 64] = sh_m;
        nframes++;
        have_prev = busy && !done;
        ehlen = 0;
      end
      if (ser_en) ehlen++;
      if (!ser_clk) lowlen++; else lowlen = 0;
      if (ser_clk) highlen++;
      p_en = ser_en; p_clk = ser_clk; p_done = done;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle(input int cap);
    int k;
    k = 0;
    while ((busy || !ser_en) && k < cap) begin
      @(negedge clk);
      k++;
    end
    check(k < cap, "R10", "completion timeout", k, cap);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input bit on, input bit off, input bit one);
    @(posedge clk); #1;
    req_on = on; req_off = off; wr_req = one;
    @(posedge clk); #1;
    req_on = 0; req_off = 0; wr_req = 0;
  endtask

  task automatic check_pins(input string req);
    check(phase_bad == 0, "R4", {req, " phase width errors"}, phase_bad, 0);
    check(bits_bad == 0, "R3", {req, " edge count/close errors"}, bits_bad, 0);
    check(open_bad == 0, "R3", {req, " frame open errors"}, open_bad, 0);
    check(gap_bad == 0, "R11", {req, " inter-write gap errors"}, gap_bad, 0);
    check(done_wide == 0, "R10", {req, " done wider than one cycle"}, done_wide, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(ser_en && ser_clk && !ser_dat, "R1", "pins in reset",
          {ser_en, ser_clk, ser_dat}, 3'b110);
    check(!busy && !done, "R1", "status in reset", {busy, done}, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(ser_en && ser_clk && !ser_dat && !busy, "R1", "pins after reset",
          {ser_en, ser_clk, ser_dat, busy}, 4'b1100);
  endtask

  task automatic t_on();
    int f0, d0;
    logic [15:0] exp_w [5];
    exp_w[0] = 16'h051E; exp_w[1] = 16'h055E; exp_w[2] = 16'h078D;
    exp_w[3] = 16'h1301; exp_w[4] = 16'h055F;
    div_half = 8'd2;
    f0 = nframes; d0 = done_cnt;
    pulse(1, 0, 0);
    @(negedge clk);
    check(busy == 1'b1, "R10", "busy after request", busy, 1);
    wait_idle(5000);
    check(nframes - f0 == 5, "R5", "on-list frame count", nframes - f0, 5);
    for (int i = 0; i < 5; i++)
      check(frames[(f0 + i) % 64] == exp_w[i], "R5", "on-list word",
            frames[(f0 + i) % 64], exp_w[i]);
    check(done_cnt - d0 == 1, "R10", "done pulses", done_cnt - d0, 1);
    check(frames[f0 % 64][15:8] == 8'h05, "R2", "address in upper byte",
          frames[f0 % 64][15:8], 8'h05);
    check_pins("R5");
  endtask

  task automatic t_off();
    int f0;
    div_half = 8'd5;
    f0 = nframes;
    pulse(0, 1, 0);
    wait_idle(5000);
    check(nframes - f0 == 1, "R6", "off-list frame count", nframes - f0, 1);
    check(frames[f0 % 64] == 16'h055E, "R6", "off-list word",
          frames[f0 % 64], 16'h055E);
    check_pins("R6");
  endtask

  task automatic t_single(input logic [7:0] a, input logic [7:0] d,
                          input logic [7:0] dv);
    int f0;
    div_half = dv;
    f0 = nframes;
    wr_addr = a; wr_data = d;
    pulse(0, 0, 1);
    wr_addr = ~a; wr_data = ~d;
    wait_idle(5000);
    check(nframes - f0 == 1, "R7", "single frame count", nframes - f0, 1);
    check(frames[f0 % 64] == {a, d}, "R7", "single word MSB first (R2)",
          frames[f0 % 64], {a, d});
    check_pins("R7");
  endtask

  task automatic t_priority();
    int f0;
    div_half = 8'd1;
    f0 = nframes;
    wr_addr = 8'hA5; wr_data = 8'h3C;
    pulse(0, 1, 1);
    wait_idle(5000);
    check(nframes - f0 == 1, "R8", "off+single frame count", nframes - f0, 1);
    check(frames[f0 % 64] == 16'h055E, "R8", "off wins over single",
          frames[f0 % 64], 16'h055E);
    f0 = nframes;
    pulse(1, 1, 1);
    wait_idle(5000);
    check(nframes - f0 == 5, "R8", "on wins over all", nframes - f0, 5);
    check(frames[(f0 + 4) % 64] == 16'h055F, "R8", "on-list last word",
          frames[(f0 + 4) % 64], 16'h055F);
  endtask

  task automatic t_busy_ignore();
    int f0, d0;
    div_half = 8'd3;
    f0 = nframes; d0 = done_cnt;
    pulse(0, 1, 0);
    repeat (20) @(negedge clk);
    wr_addr = 8'hFF; wr_data = 8'hFF;
    pulse(1, 0, 1);
    repeat (40) @(negedge clk);
    pulse(0, 1, 0);
    wait_idle(5000);
    check(nframes - f0 == 1, "R9", "frames with requests while busy",
          nframes - f0, 1);
    check(frames[f0 % 64] == 16'h055E, "R9", "word unaffected",
          frames[f0 % 64], 16'h055E);
    check(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
    check(!busy && ser_en && ser_clk, "R9", "idle afterwards",
          {busy, ser_en, ser_clk}, 3'b011);
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "R10", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    t_reset();
    t_on();
    t_off();
    t_single(8'h96, 8'h69, 8'd1);
    t_single(8'h80, 8'h01, 8'd0);
    t_priority();
    t_busy_ignore();
    div_half = 8'd4;
    t_on();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule